// File: doc/BRIEF.md
# SDRAM Byte-Mask Data Path

This block is the data side of a small SDRAM-style memory. A command carrying a direction and a start column opens a burst. Each beat of that burst either stores one 32-bit word into an internal array or fetches one word from it. The bidirectional data bus is split into three parts: an input bus, an output bus and one output enable per byte lane.

Four mask lanes, one per byte, control each beat. The mask acts differently in the two directions. On a write, a lane's mask gates the write of that byte in the same cycle as its data. On a read, a lane's mask is delayed by two clocks and then gates that lane's output enable, independently of the read latency. Bank and row handling, and commands other than read and write, are handled elsewhere in the chip.

Top module: `sdram_dpath`

## Requirements
- R1: On a write beat, every byte lane whose mask bit (bit n covers dq bits 8n+7..8n) is 0 in that cycle stores the matching byte of dq_i at the beat's column.
- R2: On a write beat, a byte lane whose mask bit is 1 leaves the stored byte at that column unchanged.
- R3: A mask bit sampled 1 at clock edge n forces that lane's output enable to 0, and that lane's dq_o byte to 0, in the clock period that ends at edge n+2.
- R4: A mask bit sampled 0 at edge n, in a period that carries read data, sets that lane's output enable to 1 and drives the stored byte on dq_o in the period that ends at edge n+2.
- R5: A command sampled at edge t performs its first beat at edge t, at the command's column; a write takes its first data word at that same edge.
- R6: Each later beat uses the previous column plus one, wrapping inside the aligned block of BURST_LEN columns (BURST_LEN is 1, 2, 4 or 8). A burst has BURST_LEN beats on consecutive edges.
- R7: The word read by a beat at edge b is on dq_o in the period that ends at edge b+CAS_LAT (CAS_LAT is 2 or 3). The mask delay stays at two clocks for either latency.
- R8: A command that arrives during a burst ends that burst at once: the new burst's first beat is at the new command's edge. Read data already fetched still appears on schedule.
- R9: While rst_ni is low, dq_oe_o and dq_o are all zeros.
- R10: Any period that carries no read data has dq_oe_o at zero, whatever the mask lanes or write beats are doing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_write_i | input | 1 | Command direction: 1 is write, 0 is read |
| cmd_col_i | input | 6 | Start column of the burst |
| dqm_i | input | 4 | Byte mask lanes, active high |
| dq_i | input | 32 | Write data |
| dq_o | output | 32 | Read data, zero on disabled lanes |
| dq_oe_o | output | 4 | Per-lane output enable |

## Verification
The hardest case to reach is a read burst in which the mask changes on every beat and also during the CAS_LAT periods after the burst. Then the enable pattern depends on mask values sampled after the beat that fetched the data. Two instances share one set of stimulus: one uses a latency of 2 and bursts of 4, the other a latency of 3 and bursts of 8. The same mask sequence therefore lands on different beats in each instance, and commands issued at short spacing cut the longer bursts in the middle. This also exercises wrap-around from unaligned start columns and a read cut short by a write.

// File: rtl/sdram_dpath_pkg.sv
package sdram_dpath_pkg;

  // Next column inside an aligned block of blen columns.
  function automatic int unsigned burst_next_col(int unsigned col, int unsigned blen);
    return (col & ~(blen - 1)) | ((col + 1) & (blen - 1));
  endfunction

endpackage

// File: rtl/sdram_burst_ctrl.sv
module sdram_burst_ctrl
  import sdram_dpath_pkg::*;
#(
  parameter int unsigned COL_W     = 6,
  parameter int unsigned BURST_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic             cmd_write_i,
  input  logic [COL_W-1:0] cmd_col_i,
  output logic             beat_o,
  output logic             beat_wr_o,
  output logic [COL_W-1:0] beat_col_o
);

  localparam int unsigned CNT_W = $clog2(BURST_LEN) + 1;
  localparam logic [CNT_W-1:0] REM_INIT = CNT_W'(BURST_LEN - 1);

  logic             busy_q;
  logic             wr_q;
  logic [COL_W-1:0] col_q;
  logic [CNT_W-1:0] rem_q;
  logic [COL_W-1:0] col_adv;

  // A new command always wins over the running burst.
  assign beat_o     = cmd_valid_i | busy_q;
  assign beat_wr_o  = cmd_valid_i ? cmd_write_i : wr_q;
  assign beat_col_o = cmd_valid_i ? cmd_col_i : col_q;
  assign col_adv    = COL_W'(burst_next_col(32'(beat_col_o), BURST_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      col_q  <= '0;
      rem_q  <= '0;
    end else if (cmd_valid_i) begin
      busy_q <= (BURST_LEN > 1);
      wr_q   <= cmd_write_i;
      col_q  <= col_adv;
      rem_q  <= REM_INIT;
    end else if (busy_q) begin
      col_q  <= col_adv;
      rem_q  <= rem_q - 1'b1;
      busy_q <= (rem_q > CNT_W'(1));
    end
  end

endmodule

// File: rtl/sdram_byte_array.sv
module sdram_byte_array #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES  = DATA_W / 8,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  mask_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && !mask_i[g]) mem_q[addr_i] <= wdata_i[g*8 +: 8];
    end

    assign rdata_o[g*8 +: 8] = mem_q[addr_i];
  end

endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CAS_LAT = 2,
  localparam int unsigned LANES   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_beat_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [LANES-1:0]  dqm_i,
  output logic [DATA_W-1:0] dq_o,
  output logic [LANES-1:0]  dq_oe_o
);

  localparam int unsigned MASK_DLY = 2;

  logic [DATA_W-1:0] data_q [CAS_LAT];
  logic [CAS_LAT-1:0] vld_q;
  logic [LANES-1:0]  dqm_q  [MASK_DLY];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int s = 0; s < MASK_DLY; s++) dqm_q[s] <= '1;
    end else begin
      vld_q    <= {vld_q[CAS_LAT-2:0], rd_beat_i};
      dqm_q[0] <= dqm_i;
      for (int s = 1; s < MASK_DLY; s++) dqm_q[s] <= dqm_q[s-1];
    end
  end

  always_ff @(posedge clk_i) begin
    data_q[0] <= rdata_i;
    for (int s = 1; s < CAS_LAT; s++) data_q[s] <= data_q[s-1];
  end

  // Mask delay is independent of the data latency.
  assign dq_oe_o = {LANES{vld_q[CAS_LAT-1]}} & ~dqm_q[MASK_DLY-1];

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign dq_o[g*8 +: 8] = data_q[CAS_LAT-1][g*8 +: 8] & {8{dq_oe_o[g]}};
  end

endmodule

// File: rtl/sdram_dpath.sv
module sdram_dpath #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned CAS_LAT   = 2,
  localparam int unsigned COL_W     = $clog2(DEPTH),
  localparam int unsigned LANES     = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_write_i,
  input  logic [COL_W-1:0]  cmd_col_i,
  input  logic [LANES-1:0]  dqm_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic [LANES-1:0]  dq_oe_o
);

  logic             beat;
  logic             beat_wr;
  logic [COL_W-1:0] beat_col;
  logic [DATA_W-1:0] rdata;
  logic             rd_beat;
  logic             wr_beat;

  assign rd_beat = beat & ~beat_wr;
  assign wr_beat = beat & beat_wr;

  sdram_burst_ctrl #(
    .COL_W    (COL_W),
    .BURST_LEN(BURST_LEN)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_write_i(cmd_write_i),
    .cmd_col_i  (cmd_col_i),
    .beat_o     (beat),
    .beat_wr_o  (beat_wr),
    .beat_col_o (beat_col)
  );

  sdram_byte_array #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W)
  ) u_array (
    .clk_i  (clk_i),
    .we_i   (wr_beat),
    .addr_i (beat_col),
    .mask_i (dqm_i),
    .wdata_i(dq_i),
    .rdata_o(rdata)
  );

  sdram_rd_pipe #(
    .DATA_W (DATA_W),
    .CAS_LAT(CAS_LAT)
  ) u_rd_pipe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_beat_i(rd_beat),
    .rdata_i  (rdata),
    .dqm_i    (dqm_i),
    .dq_o     (dq_o),
    .dq_oe_o  (dq_oe_o)
  );

endmodule

// File: rtl/sdram_dpath_chk.sv
module sdram_dpath_chk
  import sdram_dpath_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned CAS_LAT   = 2,
  localparam int unsigned COL_W     = $clog2(DEPTH),
  localparam int unsigned LANES     = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              cmd_write_i,
  input logic [LANES-1:0]  dqm_i,
  input logic [DATA_W-1:0] dq_o,
  input logic [LANES-1:0]  dq_oe_o,
  input logic              beat,
  input logic              beat_wr,
  input logic [COL_W-1:0]  beat_col
);

  assert_mask_gates_oe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_o & $past(dqm_i, 2)) == '0);

  assert_oe_needs_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dq_oe_o) |-> $past(beat && !beat_wr, CAS_LAT));

  assert_burst_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && (BURST_LEN > 1)) |=>
      (cmd_valid_i || (beat && (beat_wr == $past(cmd_write_i)))));

  assert_col_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat && !cmd_valid_i) |->
      (beat_col == COL_W'(burst_next_col(32'($past(beat_col)), BURST_LEN))));

  assert_wr_silent_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(beat && beat_wr, CAS_LAT) |-> (dq_oe_o == '0));

  assert_reset_quiet_R9: assert property (@(posedge clk_i)
    !rst_ni |-> (dq_oe_o == '0 && dq_o == '0));

endmodule

bind sdram_dpath sdram_dpath_chk #(
  .DATA_W   (DATA_W),
  .DEPTH    (DEPTH),
  .BURST_LEN(BURST_LEN),
  .CAS_LAT  (CAS_LAT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_write_i(cmd_write_i),
  .dqm_i      (dqm_i),
  .dq_o       (dq_o),
  .dq_oe_o    (dq_oe_o),
  .beat       (beat),
  .beat_wr    (beat_wr),
  .beat_col   (beat_col)
);

// File: tb/sdram_dpath_tb.sv
`timescale 1ns/1ps
module sdram_dpath_tb;

  localparam int BL0 = 4;
  localparam int CL0 = 2;
  localparam int BL1 = 8;
  localparam int CL1 = 3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_write = 1'b0;
  logic [5:0]  cmd_col = '0;
  logic [3:0]  dqm = 4'hF;
  logic [31:0] dq_in = '0;
  logic [31:0] dq0, dq1;
  logic [3:0]  oe0, oe1;

  always #2 clk = ~clk;

  sdram_dpath #(.BURST_LEN(BL0), .CAS_LAT(CL0)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_write_i(cmd_write),
    .cmd_col_i(cmd_col), .dqm_i(dqm), .dq_i(dq_in), .dq_o(dq0), .dq_oe_o(oe0));

  sdram_dpath #(.BURST_LEN(BL1), .CAS_LAT(CL1)) u_dut_b (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_write_i(cmd_write),
    .cmd_col_i(cmd_col), .dqm_i(dqm), .dq_i(dq_in), .dq_o(dq1), .dq_oe_o(oe1));

  typedef struct { int tag; logic [31:0] data; } rd_item_t;
  rd_item_t q0[$];
  rd_item_t q1[$];

  logic [31:0] mm [2][64];
  int  busy [2];
  int  col  [2];
  int  rem  [2];
  bit  wr   [2];
  logic [3:0] dqh [4096];
  int  ecount = 0;
  int  checks = 0;
  int  errors = 0;
  bit  mon_on = 1'b0;
  string req = "R9";

  always @(posedge clk) ecount <= ecount + 1;

  function automatic int wrapn(int c, int bl);
    return (c & ~(bl - 1)) | ((c + 1) & (bl - 1));
  endfunction

  // Reference for one instance at beat edge b.
  task automatic model(int d, int blen, int cl, bit cv, bit cw, int cc,
                       logic [3:0] m, logic [31:0] din, int b);
    bit beat_now = 1'b0;
    int c = 0;
    rd_item_t it;
    if (cv) begin
      beat_now = 1'b1; c = cc; wr[d] = cw; rem[d] = blen - 1;
      busy[d] = (blen > 1) ? 1 : 0; col[d] = wrapn(cc, blen);
    end else if (busy[d] != 0) begin
      beat_now = 1'b1; c = col[d]; col[d] = wrapn(col[d], blen);
      rem[d] = rem[d] - 1;
      if (rem[d] == 0) busy[d] = 0;
    end
    if (beat_now) begin
      if (wr[d]) begin
        for (int l = 0; l < 4; l++)
          if (!m[l]) mm[d][c][l*8 +: 8] = din[l*8 +: 8];
      end else begin
        it.tag = b + cl - 1;
        it.data = mm[d][c];
        if (d == 0) q0.push_back(it); else q1.push_back(it);
      end
    end
  endtask

  // Driver: called at a falling edge, returns at the next one.
  task automatic step(bit cv, bit cw, int cc, logic [3:0] m, logic [31:0] din);
    int b = ecount + 1;
    cmd_valid = cv; cmd_write = cw; cmd_col = 6'(cc); dqm = m; dq_in = din;
    dqh[b] = m;
    model(0, BL0, CL0, cv, cw, cc, m, din, b);
    model(1, BL1, CL1, cv, cw, cc, m, din, b);
    @(negedge clk);
  endtask

  task automatic idle(int n, logic [3:0] m);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, m, 32'h0);
  endtask

  function automatic logic [31:0] pat(int c);
    return 32'h3C5A_0000 ^ (32'(c) * 32'h0101_0107);
  endfunction

  task automatic check_dut(int d, logic [31:0] dq, logic [3:0] oe);
    logic [3:0]  exp_oe = 4'h0;
    logic [31:0] exp_dq = 32'h0;
    rd_item_t it;
    bit has = 1'b0;
    if (d == 0 && q0.size() > 0 && q0[0].tag == ecount) begin it = q0.pop_front(); has = 1'b1; end
    if (d == 1 && q1.size() > 0 && q1[0].tag == ecount) begin it = q1.pop_front(); has = 1'b1; end
    if (has) begin
      exp_oe = ~dqh[ecount-1];
      for (int l = 0; l < 4; l++) exp_dq[l*8 +: 8] = exp_oe[l] ? it.data[l*8 +: 8] : 8'h0;
    end
    checks++;
    if (oe !== exp_oe || dq !== exp_dq) begin
      errors++;
      $display("FAIL %s dut%0d edge %0d: oe=%h dq=%h expected oe=%h dq=%h",
               req, d, ecount, oe, dq, exp_oe, exp_dq);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      check_dut(0, dq0, oe0);
      check_dut(1, dq1, oe1);
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL %s watchdog expired", req);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4096; i++) dqh[i] = 4'hF;
    for (int d = 0; d < 2; d++) begin busy[d] = 0; col[d] = 0; rem[d] = 0; wr[d] = 0; end
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    // R9: outputs quiet in reset
    checks++;
    if (oe0 !== 4'h0 || dq0 !== 32'h0 || oe1 !== 4'h0 || dq1 !== 32'h0) begin
      errors++;
      $display("FAIL R9 reset: oe0=%h dq0=%h oe1=%h dq1=%h expected 0", oe0, dq0, oe1, dq1);
    end
    rst_ni = 1'b1;
    mon_on = 1'b1;
    idle(2, 4'hF);

    // R5: fill array, first data word with the command
    req = "R5";
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 1'b1, i*4, 4'h0, pat(i*4));
      for (int k = 1; k < 4; k++) step(1'b0, 1'b0, 0, 4'h0, pat(i*4 + k));
    end
    idle(8, 4'hF);

    // R7: read back everything with masks open
    req = "R7";
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 1'b0, i*4, 4'h0, 32'h0);
      idle(3, 4'h0);
    end
    idle(8, 4'h0);

    // R2: masked lanes keep old bytes
    req = "R2";
    step(1'b1, 1'b1, 8, 4'b0101, 32'hDEAD_BEEF);
    step(1'b0, 1'b0, 0, 4'b1010, 32'h1234_5678);
    step(1'b0, 1'b0, 0, 4'b1111, 32'hFFFF_FFFF);
    step(1'b0, 1'b0, 0, 4'b0110, 32'hCAFE_F00D);
    idle(6, 4'hF);
    step(1'b1, 1'b0, 8, 4'h0, 32'h0);
    idle(11, 4'h0);

    // R1: full-lane overwrite
    req = "R1";
    step(1'b1, 1'b1, 30, 4'h0, 32'hA1B2_C3D4);
    step(1'b0, 1'b0, 0, 4'h0, 32'h0F1E_2D3C);
    idle(8, 4'hF);
    step(1'b1, 1'b0, 28, 4'h0, 32'h0);
    idle(11, 4'h0);

    // R3 and R4: mask toggles on every read beat and after it
    req = "R3";
    step(1'b1, 1'b0, 16, 4'b0011, 32'h0);
    step(1'b0, 1'b0, 0, 4'b1100, 32'h0);
    step(1'b0, 1'b0, 0, 4'b1001, 32'h0);
    step(1'b0, 1'b0, 0, 4'b0000, 32'h0);
    step(1'b0, 1'b0, 0, 4'b0110, 32'h0);
    step(1'b0, 1'b0, 0, 4'b1111, 32'h0);
    step(1'b0, 1'b0, 0, 4'b0001, 32'h0);
    step(1'b0, 1'b0, 0, 4'b1000, 32'h0);
    step(1'b0, 1'b0, 0, 4'b0100, 32'h0);
    step(1'b0, 1'b0, 0, 4'b0010, 32'h0);
    idle(8, 4'hF);
    req = "R4";
    step(1'b1, 1'b0, 44, 4'h0, 32'h0);
    idle(11, 4'h0);

    // R6: unaligned start wraps inside its block
    req = "R6";
    step(1'b1, 1'b0, 6, 4'h0, 32'h0);
    idle(11, 4'h0);
    step(1'b1, 1'b1, 13, 4'h0, 32'h5555_AAAA);
    for (int k = 1; k < 8; k++) step(1'b0, 1'b0, 0, 4'h0, pat(100 + k));
    idle(4, 4'hF);
    step(1'b1, 1'b0, 15, 4'h0, 32'h0);
    idle(11, 4'h0);

    // R8: commands cut running bursts
    req = "R8";
    step(1'b1, 1'b0, 20, 4'h0, 32'h0);
    step(1'b0, 1'b0, 0, 4'h0, 32'h0);
    step(1'b1, 1'b0, 41, 4'h0, 32'h0);
    step(1'b0, 1'b0, 0, 4'h0, 32'h0);
    step(1'b0, 1'b0, 0, 4'h0, 32'h0);
    step(1'b1, 1'b1, 2, 4'h0, 32'h7777_0001);
    step(1'b0, 1'b0, 0, 4'h0, 32'h7777_0002);
    step(1'b1, 1'b1, 50, 4'b0011, 32'h8888_0001);
    idle(10, 4'hF);
    step(1'b1, 1'b0, 0, 4'h0, 32'h0);
    idle(11, 4'h0);
    step(1'b1, 1'b0, 48, 4'h0, 32'h0);
    idle(11, 4'h0);

    // R10: no enable during write bursts with open masks
    req = "R10";
    step(1'b1, 1'b1, 56, 4'h0, 32'h9999_0000);
    idle(10, 4'h0);

    idle(6, 4'hF);
    req = "R7";
    checks++;
    if (q0.size() != 0 || q1.size() != 0) begin
      errors++;
      $display("FAIL R7 pending read items: q0=%0d q1=%0d expected 0", q0.size(), q1.size());
    end
    finish_run();
  end

endmodule